// File: doc/BRIEF.md
# Host Register File with Indexed Display-Memory Port

This block is the host-facing control register file of a graphic display controller. A host reaches it over an 8-bit bus with an active-low chip select, active-low write and read strobes and a 5-bit register address. The block keeps the mode settings and the display geometry parameters and presents them as plain outputs to the timing and data-path logic. The timing logic needs the display start address as one 14-bit value, so that value only changes when the high half is written.

The block also provides a narrow path into display memory. A 14-bit index is split over two byte registers that can be written on their own. A data-port register turns each host access into one memory request at the current index. After that request the index steps by one and wraps from 0x257F to 0x0000. Register accesses never stall the host. A memory read adds two clocks inside the strobe window.

An access controller runs one access for each assertion of a strobe. Its states are `ST_IDLE`, `ST_MEM_WRITE`, `ST_MEM_READ`, `ST_MEM_CAPTURE` and `ST_RELEASE`, with these transitions:
- `ST_IDLE` goes to `ST_MEM_WRITE` on a data-port write, to `ST_MEM_READ` on a data-port read, and to `ST_RELEASE` on any other access. If both strobes are low, the write wins.
- `ST_MEM_WRITE` goes to `ST_RELEASE`.
- `ST_MEM_READ` goes to `ST_MEM_CAPTURE`.
- `ST_MEM_CAPTURE` goes to `ST_RELEASE`.
- `ST_RELEASE` goes back to `ST_IDLE` once both strobes have gone high.

Top module: `hreg_top`

## Requirements
- R1: After hardware reset the outputs and read-back values are as follows. Mode reads 0x00 while steal_active is 0, with lcd_en, rev_video, disp_on and timing_hold all 0 and div_code 000. line_bytes is 0x28, hsync_width 0x01, steal_width 0x00, line_count 0xF0, alt_period 0x00. start_addr is 0x0000, and both index halves read 0x00.
- R2: The register addresses are mode 0x00, line_bytes 0x02, hsync_width 0x04, steal_width 0x06, line_count 0x08, start-low 0x0A, start-high 0x0C, alt_period 0x0E, data port 0x10, index-low 0x12 and index-high 0x14. The five parameter registers (0x02, 0x04, 0x06, 0x08, 0x0E) are write-only and read as 0x00. A write to any unlisted address changes nothing, and a read from one returns 0x00.
- R3: The mode register drives the outputs as follows: bit 0 drives lcd_en, bit 1 drives rev_video, bit 2 drives disp_on, bits 5:3 drive div_code (000 = no division, 001 = 1/2, 010 = 1/4, 011 = 1/8, 100 = 1/16), and bit 6 drives timing_hold.
- R4: Mode bit 7 reads back the steal_active input, and the value written to bit 7 is dropped.
- R5: Setting the software-reset bit (mode bit 6) leaves every other register, the start address and the index unchanged.
- R6: A write to start-low is only staged and reads back at once. start_addr takes the value {start-high data bits 5:0, staged low} on the write to start-high. Start-high reads bits 7:6 as 0.
- R7: Index-low sets index bits 7:0 and index-high sets bits 13:8. Each write leaves the other half unchanged, and index-high reads bits 7:6 as 0.
- R8: A data-port write drives mem_req and mem_we high for exactly one clock, with mem_addr equal to the index and mem_wdata equal to the written byte. The index then increments by one.
- R9: A data-port read drives mem_req high with mem_we low for one clock at the index. It returns the byte that memory delivers on the following clock, and only then increments the index.
- R10: An index increment from 0x257F (or any higher value) gives 0x0000.
- R11: A strobe held low for many clocks performs exactly one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous hardware reset |
| cs_n | input | 1 | Register chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| addr | input | 5 | Register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, held until the next read |
| steal_active | input | 1 | Cycle-steal status, reported in mode bit 7 |
| mem_req | output | 1 | Display memory request, one clock long |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 14 | Memory address, equal to the index |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one clock after a read request |
| lcd_en | output | 1 | Panel power enable |
| rev_video | output | 1 | Reverse display |
| disp_on | output | 1 | Display on |
| div_code | output | 3 | Clock-divide code |
| timing_hold | output | 1 | Holds the timing counters in reset |
| line_bytes | output | 8 | Bytes shown per line |
| hsync_width | output | 8 | Line pulse width in byte times |
| steal_width | output | 8 | Cycle-steal window in byte times |
| line_count | output | 8 | Lines per frame |
| start_addr | output | 14 | Display start address |
| alt_period | output | 8 | Lines per toggle of the alternating signal, 0 = once per frame |

## Verification
Writes of distinct byte patterns to every mapped and unmapped address show whether the decoder confuses neighbouring offsets or lets odd addresses through. Mode values with different divide codes, polarity and enable bits show each output bit apart, and driving steal_active both ways with bit 7 written opposite shows that bit 7 cannot be written. Data-port runs from a mid-range index, from 0x257F, and with a strobe held for ten clocks show increment order, wrap and single-access behaviour. Start-high and index halves written with bits 7:6 set show the masking.

// File: rtl/hreg_pkg.sv
package hreg_pkg;

    localparam int DW   = 8;
    localparam int RA_W = 5;

    localparam logic [RA_W-1:0] A_MODE = 5'h00;
    localparam logic [RA_W-1:0] A_SAL  = 5'h0A;
    localparam logic [RA_W-1:0] A_SAH  = 5'h0C;
    localparam logic [RA_W-1:0] A_DP   = 5'h10;
    localparam logic [RA_W-1:0] A_IXL  = 5'h12;
    localparam logic [RA_W-1:0] A_IXH  = 5'h14;

    // write-only parameter registers: 0 line_bytes, 1 hsync_width,
    // 2 steal_width, 3 line_count, 4 alt_period
    localparam int NPAR = 5;

    function automatic logic [RA_W-1:0] par_addr(input int i);
        case (i)
            0:       return 5'h02;
            1:       return 5'h04;
            2:       return 5'h06;
            3:       return 5'h08;
            default: return 5'h0E;
        endcase
    endfunction

    function automatic logic [DW-1:0] par_reset(input int i);
        case (i)
            0:       return 8'h28;
            1:       return 8'h01;
            3:       return 8'hF0;
            default: return 8'h00;
        endcase
    endfunction

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MEM_WRITE,
        ST_MEM_READ,
        ST_MEM_CAPTURE,
        ST_RELEASE
    } acc_state_e;

endpackage

// File: rtl/hreg_access_fsm.sv
module hreg_access_fsm
    import hreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_act,
    input  logic rd_act,
    input  logic is_dp,
    output logic reg_wr_en,
    output logic reg_rd_en,
    output logic dp_latch,
    output logic mem_req,
    output logic mem_we,
    output logic dp_capture,
    output logic idx_inc
);

    acc_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_act)      state_d = is_dp ? ST_MEM_WRITE : ST_RELEASE;
                else if (rd_act) state_d = is_dp ? ST_MEM_READ  : ST_RELEASE;
            end
            ST_MEM_WRITE:   state_d = ST_RELEASE;
            ST_MEM_READ:    state_d = ST_MEM_CAPTURE;
            ST_MEM_CAPTURE: state_d = ST_RELEASE;
            ST_RELEASE:     if (!wr_act && !rd_act) state_d = ST_IDLE;
            default:        state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        reg_wr_en  = 1'b0;
        reg_rd_en  = 1'b0;
        dp_latch   = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        dp_capture = 1'b0;
        idx_inc    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                reg_wr_en = wr_act && !is_dp;
                reg_rd_en = !wr_act && rd_act && !is_dp;
                dp_latch  = wr_act && is_dp;
            end
            ST_MEM_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                idx_inc = 1'b1;
            end
            ST_MEM_READ: mem_req = 1'b1;
            ST_MEM_CAPTURE: begin
                dp_capture = 1'b1;
                idx_inc    = 1'b1;
            end
            ST_RELEASE: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/hreg_index.sv
module hreg_index #(
    parameter int          MAW     = 14,
    parameter logic [13:0] IDX_MAX = 14'h257F,
    localparam int         HI_W    = MAW - 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_lo,
    input  logic            wr_hi,
    input  logic [7:0]      lo_data,
    input  logic [HI_W-1:0] hi_data,
    input  logic            inc,
    output logic [MAW-1:0]  idx
);

    logic [MAW-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (inc) begin
            idx_q <= (idx_q >= IDX_MAX[MAW-1:0]) ? '0 : idx_q + 1'b1;
        end else begin
            if (wr_lo) idx_q[7:0]     <= lo_data;
            if (wr_hi) idx_q[MAW-1:8] <= hi_data;
        end
    end

    assign idx = idx_q;

endmodule

// File: rtl/hreg_regs.sv
module hreg_regs
    import hreg_pkg::*;
#(
    parameter int  MAW  = 14,
    localparam int HI_W = MAW - 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [RA_W-1:0]  addr,
    input  logic [DW-1:0]    wdata,
    input  logic             steal_active,
    input  logic [MAW-1:0]   idx,
    input  logic             dp_capture,
    input  logic [DW-1:0]    mem_rdata,
    output logic [DW-1:0]    rdata,
    output logic [6:0]       mode,
    output logic [DW-1:0]    par [NPAR],
    output logic [MAW-1:0]   start_addr,
    output logic             idx_wr_lo,
    output logic             idx_wr_hi
);

    logic [6:0]     mode_q;
    logic [7:0]     sal_q;
    logic [MAW-1:0] start_q;
    logic [DW-1:0]  rd_val;
    logic [DW-1:0]  rdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                        mode_q <= '0;
        else if (wr_en && addr == A_MODE)  mode_q <= wdata[6:0];
    end

    for (genvar g = 0; g < NPAR; g++) begin : g_par
        logic [DW-1:0] par_q;
        always_ff @(posedge clk) begin
            if (!rst_n)                          par_q <= par_reset(g);
            else if (wr_en && addr == par_addr(g)) par_q <= wdata;
        end
        assign par[g] = par_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sal_q   <= '0;
            start_q <= '0;
        end else if (wr_en && addr == A_SAL) begin
            sal_q <= wdata;
        end else if (wr_en && addr == A_SAH) begin
            start_q <= {wdata[HI_W-1:0], sal_q};
        end
    end

    assign idx_wr_lo = wr_en && addr == A_IXL;
    assign idx_wr_hi = wr_en && addr == A_IXH;

    always_comb begin
        unique case (addr)
            A_MODE:  rd_val = {steal_active, mode_q};
            A_SAL:   rd_val = sal_q;
            A_SAH:   rd_val = {{(8-HI_W){1'b0}}, start_q[MAW-1:8]};
            A_IXL:   rd_val = idx[7:0];
            A_IXH:   rd_val = {{(8-HI_W){1'b0}}, idx[MAW-1:8]};
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)          rdata_q <= '0;
        else if (rd_en)      rdata_q <= rd_val;
        else if (dp_capture) rdata_q <= mem_rdata;
    end

    assign rdata      = rdata_q;
    assign mode       = mode_q;
    assign start_addr = start_q;

endmodule

// File: rtl/hreg_top.sv
module hreg_top
    import hreg_pkg::*;
#(
    parameter int          MAW     = 14,
    parameter logic [13:0] IDX_MAX = 14'h257F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [RA_W-1:0]   addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic              steal_active,
    output logic              mem_req,
    output logic              mem_we,
    output logic [MAW-1:0]    mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    output logic              lcd_en,
    output logic              rev_video,
    output logic              disp_on,
    output logic [2:0]        div_code,
    output logic              timing_hold,
    output logic [DW-1:0]     line_bytes,
    output logic [DW-1:0]     hsync_width,
    output logic [DW-1:0]     steal_width,
    output logic [DW-1:0]     line_count,
    output logic [MAW-1:0]    start_addr,
    output logic [DW-1:0]     alt_period
);

    localparam int HI_W = MAW - 8;

    logic wr_act, rd_act, is_dp;
    logic reg_wr_en, reg_rd_en, dp_latch, dp_capture, idx_inc;
    logic idx_wr_lo, idx_wr_hi;
    logic [MAW-1:0] idx;
    logic [6:0]     mode;
    logic [DW-1:0]  par [NPAR];
    logic [DW-1:0]  wlatch_q;

    assign wr_act = !cs_n && !wr_n;
    assign rd_act = !cs_n && !rd_n;
    assign is_dp  = (addr == A_DP);

    hreg_access_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_act     (wr_act),
        .rd_act     (rd_act),
        .is_dp      (is_dp),
        .reg_wr_en  (reg_wr_en),
        .reg_rd_en  (reg_rd_en),
        .dp_latch   (dp_latch),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .dp_capture (dp_capture),
        .idx_inc    (idx_inc)
    );

    hreg_regs #(.MAW(MAW)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (reg_wr_en),
        .rd_en        (reg_rd_en),
        .addr         (addr),
        .wdata        (wdata),
        .steal_active (steal_active),
        .idx          (idx),
        .dp_capture   (dp_capture),
        .mem_rdata    (mem_rdata),
        .rdata        (rdata),
        .mode         (mode),
        .par          (par),
        .start_addr   (start_addr),
        .idx_wr_lo    (idx_wr_lo),
        .idx_wr_hi    (idx_wr_hi)
    );

    hreg_index #(.MAW(MAW), .IDX_MAX(IDX_MAX)) u_index (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lo   (idx_wr_lo),
        .wr_hi   (idx_wr_hi),
        .lo_data (wdata),
        .hi_data (wdata[HI_W-1:0]),
        .inc     (idx_inc),
        .idx     (idx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)        wlatch_q <= '0;
        else if (dp_latch) wlatch_q <= wdata;
    end

    assign mem_addr    = idx;
    assign mem_wdata   = wlatch_q;
    assign lcd_en      = mode[0];
    assign rev_video   = mode[1];
    assign disp_on     = mode[2];
    assign div_code    = mode[5:3];
    assign timing_hold = mode[6];
    assign line_bytes  = par[0];
    assign hsync_width = par[1];
    assign steal_width = par[2];
    assign line_count  = par[3];
    assign alt_period  = par[4];

endmodule

// File: rtl/hreg_chk.sv
module hreg_chk #(
    parameter int          MAW     = 14,
    parameter logic [13:0] IDX_MAX = 14'h257F
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cs_n,
    input logic           wr_n,
    input logic [4:0]     addr,
    input logic [7:0]     wdata,
    input logic           mem_req,
    input logic           mem_we,
    input logic [MAW-1:0] mem_addr,
    input logic           lcd_en,
    input logic           timing_hold,
    input logic [MAW-1:0] start_addr
);

    logic           have_last, ix_touch;
    logic [MAW-1:0] last_addr, next_addr;
    logic           ix_write;

    assign ix_write  = !cs_n && !wr_n && (addr == 5'h12 || addr == 5'h14);
    assign next_addr = (last_addr >= IDX_MAX[MAW-1:0]) ? '0 : last_addr + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_last <= 1'b0;
            ix_touch  <= 1'b0;
            last_addr <= '0;
        end else begin
            if (mem_req) begin
                have_last <= 1'b1;
                last_addr <= mem_addr;
            end
            if (ix_write)     ix_touch <= 1'b1;
            else if (mem_req) ix_touch <= 1'b0;
        end
    end

    assert_wr_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |=> !mem_req);

    assert_rd_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we |=> !mem_req);

    assert_dp_increment_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && have_last && !ix_touch |-> mem_addr == next_addr);

    assert_lcd_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_en) |-> $past(!cs_n && !wr_n && addr == 5'h00 && wdata[0]));

    assert_hold_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timing_hold) |-> $past(!cs_n && !wr_n && addr == 5'h00 && wdata[6]));

    assert_start_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(start_addr) |-> $past(!cs_n && !wr_n && addr == 5'h0C));

endmodule

bind hreg_top hreg_chk #(.MAW(MAW), .IDX_MAX(IDX_MAX)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .wr_n        (wr_n),
    .addr        (addr),
    .wdata       (wdata),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .lcd_en      (lcd_en),
    .timing_hold (timing_hold),
    .start_addr  (start_addr)
);

// File: tb/tb_hreg_top.sv
module tb_hreg_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
    logic [4:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        steal_active = 1'b0;
    logic        mem_req, mem_we;
    logic [13:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        lcd_en, rev_video, disp_on, timing_hold;
    logic [2:0]  div_code;
    logic [7:0]  line_bytes, hsync_width, steal_width, line_count, alt_period;
    logic [13:0] start_addr;

    int checks = 0;
    int fails  = 0;
    int req_cnt = 0;
    bit done = 1'b0;

    logic [7:0] mem [0:16383];

    always #5 clk = ~clk;

    hreg_top dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .steal_active(steal_active),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .lcd_en(lcd_en), .rev_video(rev_video), .disp_on(disp_on),
        .div_code(div_code), .timing_hold(timing_hold),
        .line_bytes(line_bytes), .hsync_width(hsync_width),
        .steal_width(steal_width), .line_count(line_count),
        .start_addr(start_addr), .alt_period(alt_period)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            req_cnt <= req_cnt + 1;
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end
    end

    initial begin
        for (int i = 0; i < 16384; i++) mem[i] = 8'(i) ^ 8'h5A;
    end

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
        end
    endtask

    task automatic do_write(input logic [4:0] a, input logic [7:0] d, input int hold = 3);
        @(negedge clk);
        addr = a; wdata = d; cs_n = 1'b0; wr_n = 1'b0;
        repeat (hold) @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_read(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; cs_n = 1'b0; rd_n = 1'b0;
        repeat (4) @(negedge clk);
        d = rdata;
        cs_n = 1'b1; rd_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic read_index(output logic [13:0] ix);
        logic [7:0] lo, hi;
        do_read(5'h12, lo);
        do_read(5'h14, hi);
        ix = {hi[5:0], lo};
    endtask

    task automatic set_index(input logic [13:0] ix);
        do_write(5'h12, ix[7:0]);
        do_write(5'h14, {2'b00, ix[13:8]});
    endtask

    task automatic t_reset;
        logic [7:0] d;
        logic [13:0] ix;
        chk("R1 lcd_en", lcd_en, 0);
        chk("R1 rev/disp/hold", {rev_video, disp_on, timing_hold}, 0);
        chk("R1 div_code", div_code, 0);
        chk("R1 line_bytes", line_bytes, 8'h28);
        chk("R1 hsync_width", hsync_width, 8'h01);
        chk("R1 steal_width", steal_width, 8'h00);
        chk("R1 line_count", line_count, 8'hF0);
        chk("R1 alt_period", alt_period, 8'h00);
        chk("R1 start_addr", start_addr, 0);
        do_read(5'h00, d);
        chk("R1 mode read", d, 8'h00);
        read_index(ix);
        chk("R1 index", ix, 0);
    endtask

    task automatic t_map;
        logic [7:0] d;
        do_write(5'h02, 8'h11);
        do_write(5'h04, 8'h22);
        do_write(5'h06, 8'h33);
        do_write(5'h08, 8'h44);
        do_write(5'h0E, 8'h55);
        chk("R2 line_bytes", line_bytes, 8'h11);
        chk("R2 hsync_width", hsync_width, 8'h22);
        chk("R2 steal_width", steal_width, 8'h33);
        chk("R2 line_count", line_count, 8'h44);
        chk("R2 alt_period", alt_period, 8'h55);
        do_read(5'h02, d);
        chk("R2 write-only reads zero", d, 0);
        do_write(5'h03, 8'hFF);
        do_write(5'h16, 8'hFF);
        chk("R2 unmapped write ignored", {line_bytes, hsync_width, line_count}, 24'h112244);
        chk("R2 unmapped write mode", {lcd_en, rev_video, disp_on, div_code, timing_hold}, 0);
        do_read(5'h03, d);
        chk("R2 unmapped read", d, 0);
    endtask

    task automatic t_mode;
        logic [7:0] d;
        do_write(5'h00, 8'h17);
        chk("R3 lcd/rev/disp", {lcd_en, rev_video, disp_on}, 3'b111);
        chk("R3 div 1/4", div_code, 3'b010);
        do_write(5'h00, 8'hA2);
        chk("R3 lcd/rev/disp b", {lcd_en, rev_video, disp_on}, 3'b010);
        chk("R3 div 1/16", div_code, 3'b100);
        do_read(5'h00, d);
        chk("R4 bit7 dropped on write", d, 8'h22);
        steal_active = 1'b1;
        do_read(5'h00, d);
        chk("R4 bit7 reports status", d, 8'hA2);
        steal_active = 1'b0;
    endtask

    task automatic t_swreset;
        logic [13:0] ix;
        do_write(5'h02, 8'h50);
        do_write(5'h0A, 8'h66);
        do_write(5'h0C, 8'h07);
        set_index(14'h0123);
        do_write(5'h00, 8'h41);
        chk("R5 hold set", timing_hold, 1);
        chk("R5 lcd kept by value", lcd_en, 1);
        chk("R5 line_bytes kept", line_bytes, 8'h50);
        chk("R5 start kept", start_addr, 14'h0766);
        read_index(ix);
        chk("R5 index kept", ix, 14'h0123);
        do_write(5'h00, 8'h00);
        chk("R5 hold clear", timing_hold, 0);
    endtask

    task automatic t_start;
        logic [7:0] d;
        do_write(5'h0A, 8'h34);
        chk("R6 low staged only", start_addr, 14'h0766);
        do_read(5'h0A, d);
        chk("R6 low reads staged", d, 8'h34);
        do_write(5'h0C, 8'hD2);
        chk("R6 commit on high", start_addr, 14'h1234);
        do_read(5'h0C, d);
        chk("R6 high bits 7:6 zero", d, 8'h12);
    endtask

    task automatic t_index;
        logic [13:0] ix;
        logic [7:0] d;
        set_index(14'h0A0B);
        do_write(5'h12, 8'hCD);
        read_index(ix);
        chk("R7 low alone", ix, 14'h0ACD);
        do_write(5'h14, 8'hF1);
        read_index(ix);
        chk("R7 high alone", ix, 14'h31CD);
        do_read(5'h14, d);
        chk("R7 high bits 7:6 zero", d, 8'h31);
    endtask

    task automatic t_dp_write;
        logic [13:0] ix;
        int r0;
        set_index(14'h0200);
        r0 = req_cnt;
        do_write(5'h10, 8'h77);
        chk("R8 one request", req_cnt - r0, 1);
        chk("R8 data at index", mem[14'h0200], 8'h77);
        do_write(5'h10, 8'h88);
        chk("R8 second at index+1", mem[14'h0201], 8'h88);
        read_index(ix);
        chk("R8 index advanced", ix, 14'h0202);
    endtask

    task automatic t_dp_read;
        logic [13:0] ix;
        logic [7:0] d;
        set_index(14'h0200);
        do_read(5'h10, d);
        chk("R9 read byte", d, 8'h77);
        do_read(5'h10, d);
        chk("R9 read next byte", d, 8'h88);
        do_read(5'h10, d);
        chk("R9 read third byte", d, 8'h02 ^ 8'h5A);
        read_index(ix);
        chk("R9 index advanced", ix, 14'h0203);
    endtask

    task automatic t_wrap;
        logic [13:0] ix;
        logic [7:0] d;
        set_index(14'h257F);
        do_read(5'h10, d);
        chk("R10 byte at top", d, 8'h7F ^ 8'h5A);
        read_index(ix);
        chk("R10 wrap to zero", ix, 0);
    endtask

    task automatic t_long;
        logic [13:0] ix;
        int r0;
        set_index(14'h0300);
        r0 = req_cnt;
        do_write(5'h10, 8'h9E, 10);
        chk("R11 one request on long strobe", req_cnt - r0, 1);
        read_index(ix);
        chk("R11 index once", ix, 14'h0301);
        do_write(5'h04, 8'h3C, 10);
        chk("R11 long register write", hsync_width, 8'h3C);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_mode();
        t_swreset();
        t_start();
        t_index();
        t_dp_write();
        t_dp_read();
        t_wrap();
        t_long();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired got=hang exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule